// File: doc/BRIEF.md
# Grouped Pin Interrupt Summary and Parent Line Controller

This block gathers the per-pin interrupt flags of a large pin controller into one compact summary. It also drives a single parent interrupt line toward the system interrupt controller. Pins are bundled in fours: summary bit n reports whether any of pins 4n, 4n+1, 4n+2 or 4n+3 has a pending event. A pin is pending when either its interrupt status or its wake status is set. With the default 184 pins the summary is 46 bits wide. Software reads it as two 32-bit words and uses the set bits to find the four-pin groups worth scanning.

The parent line is governed by a two-state machine. In ST_ARMED the line is low. The transition ARM_TO_FIRE is taken on any clock edge where at least one pending pin is also unmasked, and it moves the machine to ST_FIRING, where the line is high. The line then stays high, even if the pending flags go away, until software writes the end-of-interrupt bit. That write takes the transition FIRE_TO_ARM. Once re-armed, the machine fires again on the next edge if an unmasked pin is still pending.

Per-pin edge or level detection, masking policy and wake control are done elsewhere. This block sees only their resulting flags.

Top module: `pin_irq_aggregator`

## Requirements
- R1: Summary bit n is 1 when any of pins 4n to 4n+3 is pending, and 0 otherwise. Pins in different groups set different bits. The register read reflects the inputs one clock edge after they change.
- R2: A read at word address 0 returns summary bits 31:0. A read at word address 1 returns summary bits 45:32 in rdata[13:0], and rdata[31:14] reads as 0.
- R3: A pin counts as pending when its interrupt status alone is set, when its wake status alone is set, or when both are set.
- R4: From ST_ARMED, the parent line rises one clock edge after some pin is both pending and unmasked. A pending pin whose unmask input is 0 still sets its summary bit but never raises the line.
- R5: In ST_FIRING, the parent line stays high until an end-of-interrupt write, even if every pending flag clears.
- R6: A write to word address 2 with wdata[0]=1 is the end-of-interrupt. In ST_FIRING it drops the parent line on the next edge. If an unmasked pin is still pending, the line rises again on the edge after that.
- R7: The end-of-interrupt bit is self-clearing: word address 2 always reads 0. Word address 3 also reads 0.
- R8: Writes to word addresses 0 and 1 are ignored: they leave both the summary readback and the parent line unchanged.
- R9: While reset (rst_n=0) is asserted and after it is released with no pending inputs, the parent line is 0 and both summary words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_int_sts | input | NUM_PINS | Per-pin interrupt status flags |
| pin_wake_sts | input | NUM_PINS | Per-pin wake status flags |
| pin_unmask | input | NUM_PINS | Per-pin unmask; 1 lets the pin drive the parent line |
| reg_addr | input | 2 | Word address: 0 summary low, 1 summary high, 2 control, 3 unused |
| reg_wr | input | 1 | Write strobe, sampled on the clock edge |
| reg_wdata | input | 32 | Write data; bit 0 at address 2 is end-of-interrupt |
| reg_rdata | output | 32 | Read data for reg_addr, combinational from registered state |
| parent_irq | output | 1 | Registered parent interrupt line |

## Verification
A state machine stuck in ST_FIRING shows up as a parent line that does not drop on the edge after an end-of-interrupt write. One stuck in ST_ARMED shows up as a line that does not rise on the edge after an unmasked pin becomes pending. Either fault is visible within one cycle.

A wrong group reduction or a bad read slice shows up on the next summary read as a bit at the wrong position, a missing bit, or a nonzero value in the upper padding of the high word. The bench places single pins at the group edges, on both sides of the word boundary, to expose such offsets.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
    localparam int REG_AW   = 2;
    localparam int REG_DW   = 32;
    localparam int SUM_PADW = 64;

    localparam logic [REG_AW-1:0] ADDR_SUM_LO = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_SUM_HI = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_CTRL   = 2'd2;
    localparam int                EOI_BIT     = 0;

    typedef enum logic {
        ST_ARMED  = 1'b0,
        ST_FIRING = 1'b1
    } line_state_e;
endpackage

// File: rtl/pin_group_or.sv
module pin_group_or #(
    parameter int NUM_PINS = 184,
    parameter int GRP_SIZE = 4,
    localparam int NGROUP  = (NUM_PINS + GRP_SIZE - 1) / GRP_SIZE,
    localparam int PADDED  = NGROUP * GRP_SIZE
) (
    input  logic [NUM_PINS-1:0] pend,
    output logic [NGROUP-1:0]   grp_any
);
    logic [PADDED-1:0] pend_pad;

    generate
        if (PADDED > NUM_PINS) begin : g_pad
            assign pend_pad = {{(PADDED-NUM_PINS){1'b0}}, pend};
        end else begin : g_nopad
            assign pend_pad = pend;
        end
    endgenerate

    for (genvar g = 0; g < NGROUP; g++) begin : g_grp
        assign grp_any[g] = |pend_pad[g*GRP_SIZE +: GRP_SIZE];
    end
endmodule

// File: rtl/parent_line_fsm.sv
module parent_line_fsm
    import pin_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic eoi,
    output logic line_o
);
    line_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED:  if (req) state_d = ST_FIRING;   // ARM_TO_FIRE
            ST_FIRING: if (eoi) state_d = ST_ARMED;    // FIRE_TO_ARM
            default:   state_d = ST_ARMED;
        endcase
    end

    always_comb begin
        line_o = (state_q == ST_FIRING);
    end
endmodule

// File: rtl/summary_read_mux.sv
module summary_read_mux
    import pin_irq_pkg::*;
#(
    parameter int NGROUP = 46
) (
    input  logic [REG_AW-1:0] addr,
    input  logic [NGROUP-1:0] summary,
    output logic [REG_DW-1:0] rdata
);
    logic [SUM_PADW-1:0] wide;

    always_comb begin
        wide = '0;
        wide[NGROUP-1:0] = summary;
    end

    always_comb begin
        unique case (addr)
            ADDR_SUM_LO: rdata = wide[REG_DW-1:0];
            ADDR_SUM_HI: rdata = wide[SUM_PADW-1:REG_DW];
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/pin_irq_aggregator.sv
module pin_irq_aggregator
    import pin_irq_pkg::*;
#(
    parameter int NUM_PINS = 184,
    parameter int GRP_SIZE = 4,
    localparam int NGROUP  = (NUM_PINS + GRP_SIZE - 1) / GRP_SIZE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_int_sts,
    input  logic [NUM_PINS-1:0] pin_wake_sts,
    input  logic [NUM_PINS-1:0] pin_unmask,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [REG_DW-1:0]   reg_wdata,
    output logic [REG_DW-1:0]   reg_rdata,
    output logic                parent_irq
);
    logic [NUM_PINS-1:0] pend;
    logic [NGROUP-1:0]   grp_any;
    logic [NGROUP-1:0]   sum_q;
    logic                req;
    logic                eoi;
    logic                unused_wdata;

    assign pend         = pin_int_sts | pin_wake_sts;
    assign req          = |(pend & pin_unmask);
    assign eoi          = reg_wr && (reg_addr == ADDR_CTRL) && reg_wdata[EOI_BIT];
    assign unused_wdata = ^reg_wdata;

    pin_group_or #(.NUM_PINS(NUM_PINS), .GRP_SIZE(GRP_SIZE)) u_grp (
        .pend    (pend),
        .grp_any (grp_any)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= grp_any;
    end

    parent_line_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .eoi    (eoi),
        .line_o (parent_irq)
    );

    summary_read_mux #(.NGROUP(NGROUP)) u_rd (
        .addr    (reg_addr),
        .summary (sum_q),
        .rdata   (reg_rdata)
    );
endmodule

// File: rtl/pin_irq_aggregator_chk.sv
module pin_irq_aggregator_chk
    import pin_irq_pkg::*;
#(
    parameter int NUM_PINS = 184,
    parameter int GRP_SIZE = 4,
    localparam int NGROUP  = (NUM_PINS + GRP_SIZE - 1) / GRP_SIZE,
    localparam int HI_BITS = NGROUP - REG_DW
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] pin_int_sts,
    input logic [NUM_PINS-1:0] pin_wake_sts,
    input logic [NUM_PINS-1:0] pin_unmask,
    input logic [REG_AW-1:0]   reg_addr,
    input logic                reg_wr,
    input logic [REG_DW-1:0]   reg_wdata,
    input logic [REG_DW-1:0]   reg_rdata,
    input logic                parent_irq
);
    logic want, end_write, unused_chk;

    assign want       = |((pin_int_sts | pin_wake_sts) & pin_unmask);
    assign end_write  = reg_wr && (reg_addr == ADDR_CTRL) && reg_wdata[EOI_BIT];
    assign unused_chk = ^reg_wdata;

    AST_LINE_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (!parent_irq && want) |=> parent_irq);                       // R4
    AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(parent_irq) |-> $past(want));                          // R4
    AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (parent_irq && !end_write) |=> parent_irq);                  // R5
    AST_EOI_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (parent_irq && end_write) |=> !parent_irq);                  // R6
    AST_CTRL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_CTRL) |-> (reg_rdata == '0));              // R7
    AST_HI_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_SUM_HI) |-> (reg_rdata[REG_DW-1:HI_BITS] == '0)); // R2
endmodule

bind pin_irq_aggregator pin_irq_aggregator_chk #(
    .NUM_PINS (NUM_PINS),
    .GRP_SIZE (GRP_SIZE)
) u_chk (.*);

// File: tb/sim_pin_irq_aggregator.sv
module sim_pin_irq_aggregator;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 184;
    localparam int NV = 8;
    // pin, int status, wake status, unmask
    localparam int VEC [NV][4] = '{
        '{0,   1, 0, 1},
        '{3,   0, 1, 1},
        '{4,   1, 0, 0},
        '{127, 1, 0, 1},
        '{128, 0, 1, 1},
        '{183, 1, 1, 1},
        '{100, 0, 0, 1},
        '{61,  0, 1, 0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] i_sts = '0, w_sts = '0, umask = '0;
    logic [1:0]    addr = 2'd0;
    logic          wr = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;
    int            total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_irq_aggregator u0 (
        .clk(clk), .rst_n(rst_n), .pin_int_sts(i_sts), .pin_wake_sts(w_sts),
        .pin_unmask(umask), .reg_addr(addr), .reg_wr(wr), .reg_wdata(wdata),
        .reg_rdata(rdata), .parent_irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic clear_and_eoi();
        @(negedge clk);
        i_sts = '0; w_sts = '0; umask = '0;
        wr_reg(2'd2, 32'h1);
    endtask

    logic [31:0] v;
    logic [63:0] e;

    initial begin
        #(CLK_PERIOD*200000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R9 reset state
        repeat (3) @(negedge clk);
        chk("R9 irq in reset", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 irq after reset", {31'd0, irq}, 32'd0);
        rd(2'd0, v); chk("R9 low word", v, 32'd0);
        rd(2'd1, v); chk("R9 high word", v, 32'd0);

        // R1 R2 R3 R4 table walk
        for (int k = 0; k < NV; k++) begin
            clear_and_eoi();
            i_sts[VEC[k][0]] = VEC[k][1][0];
            w_sts[VEC[k][0]] = VEC[k][2][0];
            umask[VEC[k][0]] = VEC[k][3][0];
            e = '0;
            if (VEC[k][1] != 0 || VEC[k][2] != 0) e[VEC[k][0]/4] = 1'b1;
            @(negedge clk);
            chk($sformatf("R4 irq vec%0d", k), {31'd0, irq},
                {31'd0, (VEC[k][3] != 0) && e != 0});
            rd(2'd0, v); chk($sformatf("R1 R3 low vec%0d", k), v, e[31:0]);
            rd(2'd1, v); chk($sformatf("R2 high vec%0d", k), v, e[63:32]);
        end

        // R1 several pins: two in group 1, one in group 32
        clear_and_eoi();
        i_sts[5] = 1'b1; w_sts[6] = 1'b1; i_sts[130] = 1'b1;
        @(negedge clk);
        rd(2'd0, v); chk("R1 multi low", v, 32'h2);
        rd(2'd1, v); chk("R1 multi high", v, 32'h1);
        chk("R4 masked no irq", {31'd0, irq}, 32'd0);
        umask[130] = 1'b1;
        @(negedge clk);
        chk("R4 unmask raises", {31'd0, irq}, 32'd1);

        // R6 EOI with pin still pending, then re-arm
        wr_reg(2'd2, 32'h1);
        chk("R6 drop after eoi", {31'd0, irq}, 32'd0);
        @(negedge clk);
        chk("R6 rearm refire", {31'd0, irq}, 32'd1);

        // R5 hold after pending clears
        i_sts = '0; w_sts = '0;
        repeat (3) @(negedge clk);
        chk("R5 line held", {31'd0, irq}, 32'd1);
        rd(2'd0, v); chk("R5 summary cleared", v, 32'd0);
        wr_reg(2'd2, 32'h1);
        @(negedge clk);
        chk("R6 stays low", {31'd0, irq}, 32'd0);

        // R7 control and spare addresses read 0
        rd(2'd2, v); chk("R7 ctrl reads zero", v, 32'd0);
        rd(2'd3, v); chk("R7 spare reads zero", v, 32'd0);

        // R8 writes to summary ignored
        clear_and_eoi();
        w_sts[40] = 1'b1;
        wr_reg(2'd0, 32'hFFFF_FFFF);
        wr_reg(2'd1, 32'hFFFF_FFFF);
        rd(2'd0, v); chk("R8 low unchanged", v, 32'h400);
        rd(2'd1, v); chk("R8 high unchanged", v, 32'd0);
        chk("R8 irq unchanged", {31'd0, irq}, 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule